// File: doc/BRIEF.md
# Disk Channel Interrupt Status and Bus-Error Capture Unit

This unit gathers the interrupt sources of a single disk channel into one level interrupt line. It latches two events: a pulse meaning the device or its transfer has finished, and a pulse meaning a memory bus access made by the DMA engine failed. When the first bus error arrives, the unit stores the full 64-bit address of the failing access so that software can read it after the fact.

Software reaches the unit through a small window of 32-bit words, each chosen by a 3-bit word index. The window holds a status word, an enable word, a write-one-to-clear word and two words for the error address. The unit also watches reads of the drive's own status register. Such a read acknowledges a pending device interrupt without a separate clear, but only while the drive is not busy. The logic that makes the events, the bus and the DMA engine sit outside the unit. They appear here only as pulses, an address bus and a strobe.

Top module: `dsk_irq_ctrl`

## Requirements
- R1: Synchronous reset clears the status bits, the enable bits, the captured address and `irq`, and all window reads return 0 right after reset.
- R2: Word index 3 reads the status: bit 0 is the device-done flag and bit 1 is the bus-error flag. A pulse on `dev_done_evt` or `bus_err_evt` sets its flag at the next clock edge, and the flag stays set until it is cleared.
- R3: Writing word index 5 loads the enable bits from `host_wdata[1:0]`, using the same bit positions as the status. Reading word 5 returns the enables.
- R4: Writing word index 7 clears each status bit whose `host_wdata` bit is 1. Zero bits leave their flags unchanged.
- R5: When an event and a clear of the same flag fall in the same cycle, the event wins and the flag stays set.
- R6: `irq` is a register loaded with the OR over the flags of (status AND enable). It therefore follows the status and enable by one clock.
- R7: The first bus error while flag 1 is clear captures `bus_err_addr`. Bits 31:0 read at word index 0 and bits 63:32 read at word index 1.
- R8: Further bus errors while flag 1 is set leave the captured address unchanged. After flag 1 is cleared, the next bus error captures again.
- R9: A pulse on `drv_stat_rd` with `drv_busy` low clears flag 0. With `drv_busy` high it has no effect, and it never changes flag 1.
- R10: Word indices 2, 4 and 6 read 0. A write to word 3 changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Word index in the register window |
| host_wr | input | 1 | Write strobe for the selected word |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the selected word (combinational) |
| dev_done_evt | input | 1 | One-cycle device/transfer-complete event |
| bus_err_evt | input | 1 | One-cycle DMA memory bus error event |
| bus_err_addr | input | 64 | Address of the bus access that failed, valid with `bus_err_evt` |
| drv_stat_rd | input | 1 | Strobe: the drive status register is being read |
| drv_busy | input | 1 | Drive busy flag at the time of that read |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take several things for granted. `bus_err_addr` only matters in the cycle `bus_err_evt` is high. Event pulses and strobes are synchronous single-cycle levels that settle before the sampling edge. No input is X once reset is released. The bench drives every input at the falling edge and returns pulses to 0 after one rising edge, so each event, strobe and write is seen exactly once. It keeps `bus_err_addr` fixed whenever a capture is expected, so the captured value is known.

// File: rtl/dsk_irq_pkg.sv
`timescale 1ns/1ps
package dsk_irq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2 * DATA_W;
    localparam int IDX_W  = 3;
    localparam int NSRC   = 2;
    localparam int SRC_DEV = 0;
    localparam int SRC_BUS = 1;

    typedef enum logic [IDX_W-1:0] {
        WIN_ERR_LO = 3'd0,
        WIN_ERR_HI = 3'd1,
        WIN_STATUS = 3'd3,
        WIN_ENABLE = 3'd5,
        WIN_CLEAR  = 3'd7
    } win_idx_e;

    typedef struct packed {
        logic [NSRC-1:0] set;
        logic [NSRC-1:0] clr;
    } src_ctl_t;

    function automatic logic [DATA_W-1:0] zext_src(input logic [NSRC-1:0] v);
        return {{(DATA_W-NSRC){1'b0}}, v};
    endfunction
endpackage

// File: rtl/dsk_irq_latch.sv
`timescale 1ns/1ps
module dsk_irq_latch
    import dsk_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst)
                    flag_q <= 1'b0;
                else if (evt[i])
                    flag_q <= 1'b1;
                else if (clr[i])
                    flag_q <= 1'b0;
            end
            assign stat[i] = flag_q;

            // R2 R5
            evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> stat[i]);
            // R4
            clr_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !evt[i]) |=> !stat[i]);
        end
    endgenerate
endmodule

// File: rtl/dsk_irq_errcap.sv
`timescale 1ns/1ps
module dsk_irq_errcap
    import dsk_irq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          err_evt,
    input  logic          err_flag,
    input  logic [AW-1:0] err_addr,
    output logic [AW-1:0] addr_q
);
    logic first_err;
    assign first_err = err_evt && !err_flag;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (first_err)
            addr_q <= err_addr;
    end

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && $past(err_flag)) |-> $stable(addr_q));
endmodule

// File: rtl/dsk_irq_regs.sv
`timescale 1ns/1ps
module dsk_irq_regs
    import dsk_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   stat,
    input  logic [ADDR_W-1:0] err_addr_q,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   wr_clr,
    output logic [DATA_W-1:0] rdata
);
    logic hit_en, hit_clr;
    assign hit_en  = wr && (sel == WIN_ENABLE);
    assign hit_clr = wr && (sel == WIN_CLEAR);
    assign wr_clr  = hit_clr ? wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (hit_en)
            en_q <= wdata[NSRC-1:0];
    end

    always_comb begin
        unique case (sel)
            WIN_ERR_LO: rdata = err_addr_q[DATA_W-1:0];
            WIN_ERR_HI: rdata = err_addr_q[ADDR_W-1:DATA_W];
            WIN_STATUS: rdata = zext_src(stat);
            WIN_ENABLE: rdata = zext_src(en_q);
            default:    rdata = '0;
        endcase
    end

    // R3
    en_load_chk: assert property (@(posedge clk) disable iff (rst)
        hit_en |=> (en_q == $past(wdata[NSRC-1:0])));
endmodule

// File: rtl/dsk_irq_ctrl.sv
`timescale 1ns/1ps
module dsk_irq_ctrl
    import dsk_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  host_sel,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dev_done_evt,
    input  logic              bus_err_evt,
    input  logic [ADDR_W-1:0] bus_err_addr,
    input  logic              drv_stat_rd,
    input  logic              drv_busy,
    output logic              irq
);
    src_ctl_t          ctl;
    logic [NSRC-1:0]   stat, en_q, wr_clr;
    logic [ADDR_W-1:0] addr_q;
    logic              drv_ack, irq_q;

    assign drv_ack = drv_stat_rd && !drv_busy;

    always_comb begin
        ctl.set          = '0;
        ctl.set[SRC_DEV] = dev_done_evt;
        ctl.set[SRC_BUS] = bus_err_evt;
        ctl.clr          = wr_clr;
        ctl.clr[SRC_DEV] = wr_clr[SRC_DEV] | drv_ack;
    end

    dsk_irq_latch #(.N(NSRC)) u_latch (
        .clk(clk), .rst(rst), .evt(ctl.set), .clr(ctl.clr), .stat(stat)
    );

    dsk_irq_errcap #(.AW(ADDR_W)) u_errcap (
        .clk(clk), .rst(rst), .err_evt(bus_err_evt), .err_flag(stat[SRC_BUS]),
        .err_addr(bus_err_addr), .addr_q(addr_q)
    );

    dsk_irq_regs u_regs (
        .clk(clk), .rst(rst), .sel(host_sel), .wr(host_wr), .wdata(host_wdata),
        .stat(stat), .err_addr_q(addr_q), .en_q(en_q), .wr_clr(wr_clr),
        .rdata(host_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(stat & en_q);
    end
    assign irq = irq_q;

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(stat & en_q)));
    // R9
    drv_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_ack && !dev_done_evt) |=> !stat[SRC_DEV]);
    // R9
    drv_ack_keeps_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (stat[SRC_BUS] && !host_wr && drv_stat_rd) |=> stat[SRC_BUS]);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && stat == '0 && en_q == '0));
endmodule

// File: tb/tb_dsk_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dsk_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_sel = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dev_done_evt = 1'b0, bus_err_evt = 1'b0;
    logic [63:0] bus_err_addr = '0;
    logic        drv_stat_rd = 1'b0, drv_busy = 1'b0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dsk_irq_ctrl dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_done_evt(dev_done_evt), .bus_err_evt(bus_err_evt),
        .bus_err_addr(bus_err_addr), .drv_stat_rd(drv_stat_rd),
        .drv_busy(drv_busy), .irq(irq)
    );

    // {dev, err, wr, sel[2:0], wd[1:0], exp_stat[1:0], exp_irq}
    localparam int NV = 13;
    localparam logic [10:0] VEC [NV] = '{
        11'b0_0_1_101_01_00_0,  // enable bit0 (R3)
        11'b1_0_0_000_00_01_0,  // device event (R2)
        11'b0_0_0_000_00_01_1,  // irq one clock later (R6)
        11'b0_1_0_000_00_11_1,  // bus error (R2)
        11'b0_0_1_111_01_10_1,  // clear bit0 (R4)
        11'b0_0_0_000_00_10_0,  // bit1 not enabled (R6)
        11'b0_0_1_101_11_10_0,  // enable both (R3)
        11'b0_0_0_000_00_10_1,  // irq from bit1 (R6)
        11'b1_0_1_111_11_01_1,  // event beats clear (R5)
        11'b0_0_1_011_11_01_1,  // status write ignored (R10)
        11'b0_0_1_111_00_01_1,  // zero clear ignored (R4)
        11'b0_0_1_111_01_00_1,  // clear bit0 (R4)
        11'b0_0_0_000_00_00_0   // irq drops (R6)
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic dev, logic err, logic wr, logic [2:0] sel, logic [31:0] wd);
        @(negedge clk);
        dev_done_evt = dev; bus_err_evt = err; host_wr = wr;
        host_sel = sel; host_wdata = wd;
        @(posedge clk); #1;
        dev_done_evt = 0; bus_err_evt = 0; host_wr = 0; drv_stat_rd = 0;
    endtask

    task automatic peek(logic [2:0] sel, output logic [31:0] d);
        host_sel = sel; #1; d = host_rdata;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        // R1 reset state
        peek(3'd3, d); chk("R1 status", d, 0);
        peek(3'd5, d); chk("R1 enable", d, 0);
        peek(3'd0, d); chk("R1 addr lo", d, 0);
        chk("R1 irq", irq, 0);

        bus_err_addr = 64'h0BAD_F00D_1234_5678;
        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            step(v[10], v[9], v[8], v[7:5], {30'd0, v[4:3]});
            peek(3'd3, d);
            chk($sformatf("vector %0d status R2 R4 R5 R10", i), d, {30'd0, v[2:1]});
            chk($sformatf("vector %0d irq R6", i), irq, v[0]);
        end

        // error address capture
        step(0, 0, 1, 3'd5, 0);
        step(0, 0, 1, 3'd7, 3);
        bus_err_addr = 64'h1122_3344_5566_7788;
        step(0, 1, 0, 3'd0, 0);
        peek(3'd0, d); chk("R7 addr lo", d, 32'h5566_7788);
        peek(3'd1, d); chk("R7 addr hi", d, 32'h1122_3344);
        bus_err_addr = 64'hAAAA_BBBB_CCCC_DDDD;
        step(0, 1, 0, 3'd0, 0);
        peek(3'd0, d); chk("R8 held lo", d, 32'h5566_7788);
        peek(3'd1, d); chk("R8 held hi", d, 32'h1122_3344);
        step(0, 0, 1, 3'd7, 2);
        peek(3'd3, d); chk("R4 bit1 cleared", d, 0);
        step(0, 1, 0, 3'd0, 0);
        peek(3'd0, d); chk("R8 recapture lo", d, 32'hCCCC_DDDD);
        peek(3'd1, d); chk("R8 recapture hi", d, 32'hAAAA_BBBB);

        // drive status read acknowledge
        step(1, 0, 0, 3'd0, 0);
        peek(3'd3, d); chk("R2 both set", d, 3);
        drv_stat_rd = 1; drv_busy = 1;
        step(0, 0, 0, 3'd0, 0);
        peek(3'd3, d); chk("R9 busy read ignored", d, 3);
        drv_stat_rd = 1; drv_busy = 0;
        step(0, 0, 0, 3'd0, 0);
        peek(3'd3, d); chk("R9 ack clears bit0 only", d, 2);

        // unmapped words and enable readback
        peek(3'd2, d); chk("R10 word2", d, 0);
        peek(3'd4, d); chk("R10 word4", d, 0);
        peek(3'd6, d); chk("R10 word6", d, 0);
        step(0, 0, 1, 3'd5, 32'hFFFF_FFFE);
        peek(3'd5, d); chk("R3 enable readback", d, 2);
        chk("R6 irq not yet", irq, 0);
        step(0, 0, 0, 3'd0, 0);
        chk("R6 irq bit1 enabled", irq, 1);

        // reset mid-operation
        rst = 1;
        step(0, 0, 0, 3'd0, 0);
        rst = 0;
        peek(3'd3, d); chk("R1 status after reset", d, 0);
        peek(3'd5, d); chk("R1 enable after reset", d, 0);
        peek(3'd1, d); chk("R1 addr hi after reset", d, 0);
        chk("R1 irq after reset", irq, 0);

        finish_run();
    end
endmodule